// File: doc/BRIEF.md
# Synchronous 8-to-6 Lane Ratio Converter

This block moves a lane stream from a slower clock domain A into a faster domain B. The two clocks come from one source and run at an exact 3:4 frequency ratio. Domain A delivers a word of eight lanes on every A cycle. Domain B emits a word of six lanes on every B cycle. The lane rate is therefore the same on both sides, and no FIFO is needed. A hop buffer of three eight-lane segments holds one common period of data. A common period is three A cycles, or four B cycles.

Domain A keeps a phase counter that selects the segment each A edge loads. A period marker flips in domain A once per common period. Domain B samples the marker and derives its own four-step phase from it. That phase then acts as the enable that picks, on each B edge, which buffer lanes go out. The fixed selection keeps the output stream identical to the input stream, lane for lane and in order. The lane width is a parameter, and the A word width is a parameter that must be a multiple of four lanes.

Top module: `rwc_ratio_conv`

## Requirements
- R1: While `rst_b` is high, and after it until the first valid word, `b_valid` is 0 and `b_data` is 0. The A phase counter leaves reset so that the first A edge with `rst_a` low loads segment 1. `rst_a` must therefore be released so that this edge falls one A cycle after an edge that both clocks share.
- R2: The buffer has three segments, and buffer lane index = segment × A_LANES + lane. An A edge at phase p copies `a_data` into segment p and leaves the other two segments unchanged. The A phase steps 1, 2, 0, 1, …
- R3: The period marker changes on every A edge that loads segment 1, and on no other A edge.
- R4: The B edge that first sees the marker changed is B phase 2. The next B edge is phase 3, and the phase then counts 0, 1, 2, 3 and wraps.
- R5: At B phase p, output lane j carries buffer lane (B_LANES·p + j + A_LANES) mod (3·A_LANES). With eight and six lanes this gives:
  - phase 0: segment 1 lanes 0–5
  - phase 1: segment 1 lanes 6–7, then segment 2 lanes 0–3
  - phase 2: segment 2 lanes 4–7, then segment 0 lanes 0–1
  - phase 3: segment 0 lanes 2–7
- R6: `b_valid` first rises after the first phase-0 B edge that follows lock, and it then stays high on every B cycle until `rst_b`.
- R7: Read in order, with output lane 0 earliest, the valid B words equal the A input stream with no lane lost or repeated. The first valid word starts at lane 0 of the first A word loaded after reset.
- R8: A reset of B alone does not disturb domain A. B keeps sampling the marker during the reset and locks again at the next phase-2 edge. Valid output resumes at the phase-0 edge after that, with the lanes that belong to that edge's place in the stream.
- R9: Whenever `b_valid` is 0, `b_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Slow clock; three cycles per common period |
| rst_a | input | 1 | Synchronous active-high reset, domain A |
| a_data | input | LANE_W·A_LANES | Input word, lane 0 in the low bits |
| clk_b | input | 1 | Fast clock; four cycles per common period |
| rst_b | input | 1 | Synchronous active-high reset, domain B |
| b_data | output | LANE_W·A_LANES·3/4 | Output word, lane 0 in the low bits |
| b_valid | output | 1 | Output word carries stream lanes |

## Verification
The bench builds the block with 12-bit lanes and eight input lanes. Each lane value is an affine function of the lane's position in the stream, modulo 4096. Every lane of a run of about four thousand lanes is therefore distinct, so a dropped, repeated or misplaced lane cannot match by chance. The clocks run at 5 ns and 3.75 ns, so that every segment, every B phase and the mid-run reset of B alone with its re-lock are covered over many common periods.

// File: rtl/rwc_pkg.sv
`timescale 1ns/1ps
package rwc_pkg;
    localparam int A_PHASES = 3;
    localparam int B_PHASES = 4;

    typedef logic [1:0] phase_t;

    // Segment whose load flips the period marker
    localparam phase_t MARK_SEG   = 2'd1;
    // B phase on which a marker change becomes visible
    localparam phase_t SEEN_PHASE = 2'd2;

    function automatic phase_t a_step(phase_t p);
        return (p == phase_t'(A_PHASES - 1)) ? 2'd0 : p + 2'd1;
    endfunction
endpackage

// File: rtl/rwc_hop_writer.sv
`timescale 1ns/1ps
module rwc_hop_writer
    import rwc_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int A_LANES = 8
) (
    input  logic                                  clk_a,
    input  logic                                  rst_a,
    input  logic [LANE_W*A_LANES-1:0]             a_data,
    output logic [LANE_W*A_LANES*A_PHASES-1:0]    hop_buf,
    output phase_t                                a_phase,
    output logic                                  mark
);
    localparam int SEG_W = LANE_W * A_LANES;
    localparam int BUF_W = SEG_W * A_PHASES;

    typedef struct packed {
        logic [BUF_W-1:0] segs;
        phase_t           phase;
        logic             mark;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_a) begin
            st_d.segs  = '0;
            st_d.phase = MARK_SEG;
            st_d.mark  = 1'b0;
        end else begin
            for (int s = 0; s < A_PHASES; s++) begin
                if (st_q.phase == phase_t'(s)) begin
                    st_d.segs[s*SEG_W +: SEG_W] = a_data;
                end
            end
            if (st_q.phase == MARK_SEG) begin
                st_d.mark = ~st_q.mark;
            end
            st_d.phase = a_step(st_q.phase);
        end
    end

    always_ff @(posedge clk_a) begin
        st_q <= st_d;
    end

    assign hop_buf = st_q.segs;
    assign a_phase = st_q.phase;
    assign mark    = st_q.mark;
endmodule

// File: rtl/rwc_phase_track.sv
`timescale 1ns/1ps
module rwc_phase_track
    import rwc_pkg::*;
(
    input  logic   clk_b,
    input  logic   rst_b,
    input  logic   mark,
    output phase_t b_phase,
    output logic   locked,
    output logic   seen
);
    typedef struct packed {
        logic   mark_s;
        phase_t phase;
        logic   locked;
    } trk_state_t;

    trk_state_t st_d, st_q;

    assign seen = (mark != st_q.mark_s);

    always_comb begin
        st_d        = st_q;
        // keep following the marker even in reset, so release never sees a stale edge
        st_d.mark_s = mark;
        if (rst_b) begin
            st_d.phase  = 2'd0;
            st_d.locked = 1'b0;
        end else if (seen) begin
            st_d.phase  = SEEN_PHASE + 2'd1;
            st_d.locked = 1'b1;
        end else if (st_q.locked) begin
            st_d.phase  = st_q.phase + 2'd1;
        end
    end

    always_ff @(posedge clk_b) begin
        st_q <= st_d;
    end

    assign b_phase = st_q.phase;
    assign locked  = st_q.locked;
endmodule

// File: rtl/rwc_lane_pick.sv
`timescale 1ns/1ps
module rwc_lane_pick
    import rwc_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int A_LANES = 8
) (
    input  logic [LANE_W*A_LANES*A_PHASES-1:0]          hop_buf,
    input  phase_t                                      b_phase,
    output logic [LANE_W*(A_LANES*A_PHASES/B_PHASES)-1:0] word
);
    localparam int TOTAL   = A_LANES * A_PHASES;
    localparam int B_LANES = TOTAL / B_PHASES;
    localparam int B_W     = LANE_W * B_LANES;

    logic [B_PHASES-1:0][B_W-1:0] cand;

    for (genvar p = 0; p < B_PHASES; p++) begin : g_phase
        for (genvar j = 0; j < B_LANES; j++) begin : g_lane
            localparam int SRC = (B_LANES * p + j + A_LANES) % TOTAL;
            assign cand[p][j*LANE_W +: LANE_W] = hop_buf[SRC*LANE_W +: LANE_W];
        end
    end

    assign word = cand[b_phase];
endmodule

// File: rtl/rwc_ratio_conv.sv
`timescale 1ns/1ps
module rwc_ratio_conv
    import rwc_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int A_LANES = 8
) (
    input  logic                                 clk_a,
    input  logic                                 rst_a,
    input  logic [LANE_W*A_LANES-1:0]            a_data,
    input  logic                                 clk_b,
    input  logic                                 rst_b,
    output logic [LANE_W*(A_LANES*3/4)-1:0]      b_data,
    output logic                                 b_valid
);
    localparam int B_LANES = A_LANES * A_PHASES / B_PHASES;
    localparam int B_W     = LANE_W * B_LANES;
    localparam int BUF_W   = LANE_W * A_LANES * A_PHASES;

    logic [BUF_W-1:0] hop_buf;
    phase_t           wr_phase;
    logic             wr_mark;
    phase_t           trk_phase;
    logic             trk_locked;
    logic             trk_seen;
    logic [B_W-1:0]   pick_word;

    rwc_hop_writer #(.LANE_W(LANE_W), .A_LANES(A_LANES)) u_writer (
        .clk_a   (clk_a),
        .rst_a   (rst_a),
        .a_data  (a_data),
        .hop_buf (hop_buf),
        .a_phase (wr_phase),
        .mark    (wr_mark)
    );

    rwc_phase_track u_track (
        .clk_b   (clk_b),
        .rst_b   (rst_b),
        .mark    (wr_mark),
        .b_phase (trk_phase),
        .locked  (trk_locked),
        .seen    (trk_seen)
    );

    rwc_lane_pick #(.LANE_W(LANE_W), .A_LANES(A_LANES)) u_pick (
        .hop_buf (hop_buf),
        .b_phase (trk_phase),
        .word    (pick_word)
    );

    typedef struct packed {
        logic [B_W-1:0] data;
        logic           valid;
        logic           run;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (rst_b) begin
            out_d = '0;
        end else if (trk_locked && (trk_phase == 2'd0 || out_q.run)) begin
            out_d.data  = pick_word;
            out_d.valid = 1'b1;
            out_d.run   = 1'b1;
        end else begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk_b) begin
        out_q <= out_d;
    end

    assign b_data  = out_q.data;
    assign b_valid = out_q.valid;
endmodule

// File: rtl/rwc_ratio_conv_chk.sv
`timescale 1ns/1ps
module rwc_ratio_conv_chk
    import rwc_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int A_LANES = 8
) (
    input logic                                clk_a,
    input logic                                rst_a,
    input logic                                clk_b,
    input logic                                rst_b,
    input phase_t                              a_phase,
    input logic                                mark,
    input logic [LANE_W*A_LANES*A_PHASES-1:0]  hop_buf,
    input phase_t                              b_phase,
    input logic                                locked,
    input logic                                seen,
    input logic                                b_valid,
    input logic [LANE_W*(A_LANES*3/4)-1:0]     b_data
);
    localparam int SEG_W = LANE_W * A_LANES;

    AST_SEG1_KEEP: assert property (@(posedge clk_a) disable iff (rst_a)
        (!$past(rst_a) && $past(a_phase) != 2'd1) |-> $stable(hop_buf[SEG_W +: SEG_W])); // R2

    AST_MARK_ON_SEG1: assert property (@(posedge clk_a) disable iff (rst_a)
        (!$past(rst_a) && !$stable(mark)) |-> $past(a_phase) == 2'd1); // R3

    AST_SEEN_PHASE2: assert property (@(posedge clk_b) disable iff (rst_b)
        (seen && locked) |-> b_phase == 2'd2); // R4

    AST_PHASE_WRAP: assert property (@(posedge clk_b) disable iff (rst_b)
        (locked && $past(locked)) |-> b_phase == $past(b_phase) + 2'd1); // R4

    AST_VALID_HOLD: assert property (@(posedge clk_b) disable iff (rst_b)
        b_valid |=> b_valid); // R6

    AST_VALID_START: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_valid && !$past(b_valid)) |-> $past(b_phase) == 2'd0); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk_b) disable iff (rst_b)
        !b_valid |-> b_data == '0); // R9
endmodule

bind rwc_ratio_conv rwc_ratio_conv_chk #(.LANE_W(LANE_W), .A_LANES(A_LANES)) u_chk (
    .clk_a   (clk_a),
    .rst_a   (rst_a),
    .clk_b   (clk_b),
    .rst_b   (rst_b),
    .a_phase (wr_phase),
    .mark    (wr_mark),
    .hop_buf (hop_buf),
    .b_phase (trk_phase),
    .locked  (trk_locked),
    .seen    (trk_seen),
    .b_valid (b_valid),
    .b_data  (b_data)
);

// File: tb/rwc_ratio_conv_test.sv
`timescale 1ns/1ps
module rwc_ratio_conv_test;
    localparam int LW = 12;
    localparam int AL = 8;
    localparam int BL = 6;
    localparam int FIRST_OUT = 20;   // first phase-0 B edge after lock
    localparam int LAST_EDGE = 700;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_a = 1'b1;
    logic rst_b = 1'b1;
    logic [AL*LW-1:0] a_data = '0;
    logic [BL*LW-1:0] b_data;
    logic             b_valid;

    int total = 0;
    int bad   = 0;
    int ca    = 0;
    int cb    = 0;

    rwc_ratio_conv #(.LANE_W(LW), .A_LANES(AL)) uut (
        .clk_a   (clk_a),
        .rst_a   (rst_a),
        .a_data  (a_data),
        .clk_b   (clk_b),
        .rst_b   (rst_b),
        .b_data  (b_data),
        .b_valid (b_valid)
    );

    // A: 200 MHz; B: 3.75 ns; rising edges coincide at 2.5 ns + k*15 ns
    initial forever #2.5 clk_a = ~clk_a;
    initial begin
        #0.625;
        forever #1.875 clk_b = ~clk_b;
    end

    always @(posedge clk_a) ca <= ca + 1;
    always @(posedge clk_b) cb <= cb + 1;

    function automatic logic [LW-1:0] lane_val(int n);
        return LW'((n * 5 + 3) % 4096);
    endfunction

    task automatic check(bit ok, string tag, string what, int edge_no,
                         logic [BL*LW-1:0] act, logic [BL*LW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s B edge %0d %s: actual=%h expected=%h", tag, edge_no, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // A edge 12 (62.5 ns) is shared by both clocks; edge 13 is the first with rst_a low (R1)
    initial begin
        #63.5 rst_a = 1'b0;
    end

    initial begin
        forever begin
            @(negedge clk_a);
            for (int i = 0; i < AL; i++) begin
                a_data[i*LW +: LW] = (ca >= 13) ? lane_val(AL * (ca - 13) + i) : LW'(12'hA5C);
            end
        end
    end

    initial begin
        logic [BL*LW-1:0] exp_w;
        bit               exp_v;
        string            vtag;
        string            dtag;
        int               m;
        while (cb < LAST_EDGE) begin
            @(negedge clk_b);
            m = cb - 1;
            if (m >= 0) begin
                exp_v = (m >= FIRST_OUT) && !(m >= 100 && m <= 111);
                if (m < 10)                  vtag = "R1";
                else if (m == FIRST_OUT - 1) vtag = "R3";
                else if (m == FIRST_OUT)     vtag = "R4";
                else if (m >= 100 && m <= 112) vtag = "R8";
                else                         vtag = "R6";
                check(b_valid === exp_v, vtag, "valid", m,
                      {{(BL*LW-1){1'b0}}, b_valid}, {{(BL*LW-1){1'b0}}, exp_v});
                if (exp_v) begin
                    for (int j = 0; j < BL; j++) begin
                        exp_w[j*LW +: LW] = lane_val(BL * (m - FIRST_OUT) + j);
                    end
                    if (m < FIRST_OUT + 4)   dtag = "R2";
                    else if (m < 100)        dtag = "R5";
                    else if (m < 120)        dtag = "R8";
                    else                     dtag = "R7";
                end else begin
                    exp_w = '0;
                    dtag  = (m < 10) ? "R1" : "R9";
                end
                check(b_data === exp_w, dtag, "data", m, b_data, exp_w);
            end
            rst_b = (cb < 10) || (cb >= 100 && cb < 108);
        end
        summary();
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
        $finish;
    end
endmodule